// File: doc/BRIEF.md
# Key-Locked Watchdog Controller

This block is a watchdog timer whose configuration sits behind a pair of byte-wide host ports: an index port that picks a register and a data port that reads or writes it. The configuration space stays closed until software writes a two-byte open key to the index port. Software then selects the watchdog page through a page register, programs the timeout, the count unit, the enable bit and the restart sources, and writes a close key to shut the space again. Host address decoding is not part of the block. A single select input tells it whether a write is aimed at the index port or at the data port.

The timer counts down on an external one-second tick. In minutes mode it counts once per minute, using an internal prescaler over those ticks. A write of the timeout register loads the count and also acts as the keepalive. Keyboard or mouse interrupt pulses can reload the count if their restart bits are set. When the count runs out while the timer is enabled, the block raises a one-cycle reset pulse and clears its own enable bit.

Top module: `kl_wdog_ctrl`

## Requirements
- R1: After reset the configuration space is closed, the data port reads 0x00, `wdt_rst` is low, and every watchdog register is zero.
- R2: Two index-port writes of 0x87 with nothing between them open the configuration space. Data-port writes and other index writes made while it is closed have no effect.
- R3: An index write of any value other than 0x87 after the first key write cancels the unlock. The next 0x87 counts as a new first key.
- R4: With the space open, index 0x07 reaches the page register. Writing data 0x08 there selects the watchdog page. Until that page is selected, the watchdog registers read 0x00 and ignore writes.
- R5: On the watchdog page the registers are laid out as follows. Index 0x30 bit 0 is the enable. Index 0xF5 bit 3 is the unit (0 = seconds, 1 = minutes). Index 0xF7 bit 6 is the keyboard restart and bit 7 is the mouse restart. All other bits of these registers read 0, and an index with no register behind it reads 0x00.
- R6: An index write of 0xAA while open closes the space and clears the page register to 0x00. After that the data port reads 0x00 and data writes are ignored.
- R7: In seconds mode, each `sec_tick` pulse while the timer is enabled lowers the count by one. The count is read at index 0xF6. While the timer is disabled, ticks leave the count unchanged.
- R8: A counting tick that finds the count at 1 or 0 while enabled sets the count to 0. It also clears the enable bit and drives `wdt_rst` high for exactly one cycle, starting on the next clock edge.
- R9: A data write to index 0xF6 sets both the reload value and the live count to the written byte, and restarts the minute prescaler.
- R10: While enabled, a `kbd_irq` pulse with bit 6 set, or a `mouse_irq` pulse with bit 7 set, reloads the count from the reload value. With the bit clear, the pulse is ignored.
- R11: In minutes mode the count drops once for every SEC_PER_MIN ticks.
- R12: A write of index 0xF6, or a permitted interrupt restart, in the same cycle as the tick that would expire the timer takes priority. The count is reloaded, no reset pulse follows, and the enable bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe, one cycle per byte |
| host_port | input | 1 | Port select: 0 = index port, 1 = data port |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Data-port read value for the current index |
| sec_tick | input | 1 | One-cycle pulse once per second |
| kbd_irq | input | 1 | Keyboard interrupt pulse |
| mouse_irq | input | 1 | Mouse interrupt pulse |
| wdt_rst | output | 1 | One-cycle reset pulse on expiry |

## Verification
Two functions can act in the same cycle: the tick that would expire the timer, and a keepalive that reloads the count. The keepalive can be a data write of the timeout register or an enabled interrupt restart. The bench brings the count down to 1. It then drives the final tick in the same cycle as the data write, and in a later run in the same cycle as a mouse interrupt. A correct design shows the reloaded count at index 0xF6, keeps the enable bit set, and gives no reset pulse at all; the bench counts every cycle in which the reset output is high.

// File: rtl/kl_wdog_pkg.sv
package kl_wdog_pkg;
  localparam logic [7:0] KEY_OPEN  = 8'h87;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;
  localparam logic [7:0] IDX_PAGE  = 8'h07;
  localparam logic [7:0] PAGE_WD   = 8'h08;
  localparam logic [7:0] IDX_EN    = 8'h30;
  localparam logic [7:0] IDX_UNIT  = 8'hF5;
  localparam logic [7:0] IDX_TMO   = 8'hF6;
  localparam logic [7:0] IDX_RSRC  = 8'hF7;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_HALF   = 2'd1,
    ST_OPEN   = 2'd2
  } key_st_t;
endpackage

// File: rtl/kl_key_fsm.sv
module kl_key_fsm
  import kl_wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open,
  output logic       close_evt,
  output logic [7:0] idx_q
);
  key_st_t    st_q, st_d;
  logic [7:0] idx_d;

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    close_evt = 1'b0;
    if (idx_wr) begin
      case (st_q)
        ST_LOCKED: if (wdata == KEY_OPEN) st_d = ST_HALF;
        ST_HALF:   st_d = (wdata == KEY_OPEN) ? ST_OPEN : ST_LOCKED;
        ST_OPEN: begin
          if (wdata == KEY_CLOSE) begin
            st_d      = ST_LOCKED;
            idx_d     = '0;
            close_evt = 1'b1;
          end else begin
            idx_d = wdata;
          end
        end
        default:   st_d = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_LOCKED;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign cfg_open = (st_q == ST_OPEN);
endmodule

// File: rtl/kl_wd_regs.sv
module kl_wd_regs
  import kl_wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_open,
  input  logic       close_evt,
  input  logic       dat_wr,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  input  logic       expire,
  input  logic [7:0] cnt,
  output logic       en_o,
  output logic       unit_min_o,
  output logic [7:0] tmo_o,
  output logic       kb_en_o,
  output logic       ms_en_o,
  output logic       tmo_wr_o,
  output logic [7:0] page_o,
  output logic [7:0] rdata
);
  logic       sel_pg;
  logic       wr_page, wr_en, wr_unit, wr_rsrc;
  logic [7:0] page_d, tmo_d;
  logic       en_d, unit_d, kb_d, ms_d;

  assign sel_pg   = cfg_open && (page_o == PAGE_WD);
  assign wr_page  = dat_wr && cfg_open && (idx == IDX_PAGE);
  assign wr_en    = dat_wr && sel_pg && (idx == IDX_EN);
  assign wr_unit  = dat_wr && sel_pg && (idx == IDX_UNIT);
  assign tmo_wr_o = dat_wr && sel_pg && (idx == IDX_TMO);
  assign wr_rsrc  = dat_wr && sel_pg && (idx == IDX_RSRC);

  always_comb begin
    page_d = page_o;
    en_d   = en_o;
    unit_d = unit_min_o;
    tmo_d  = tmo_o;
    kb_d   = kb_en_o;
    ms_d   = ms_en_o;
    if (close_evt)    page_d = '0;
    else if (wr_page) page_d = wdata;
    if (wr_en)        en_d = wdata[0];
    else if (expire)  en_d = 1'b0;
    if (wr_unit)      unit_d = wdata[3];
    if (tmo_wr_o)     tmo_d = wdata;
    if (wr_rsrc) begin
      kb_d = wdata[6];
      ms_d = wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_o     <= '0;
      en_o       <= 1'b0;
      unit_min_o <= 1'b0;
      tmo_o      <= '0;
      kb_en_o    <= 1'b0;
      ms_en_o    <= 1'b0;
    end else begin
      page_o     <= page_d;
      en_o       <= en_d;
      unit_min_o <= unit_d;
      tmo_o      <= tmo_d;
      kb_en_o    <= kb_d;
      ms_en_o    <= ms_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (cfg_open) begin
      if (idx == IDX_PAGE) rdata = page_o;
      else if (sel_pg) begin
        case (idx)
          IDX_EN:   rdata = {7'b0, en_o};
          IDX_UNIT: rdata = {4'b0, unit_min_o, 3'b0};
          IDX_TMO:  rdata = cnt;
          IDX_RSRC: rdata = {ms_en_o, kb_en_o, 6'b0};
          default:  rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/kl_wd_timer.sv
module kl_wd_timer #(
  parameter int SEC_PER_MIN = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       en,
  input  logic       unit_min,
  input  logic [7:0] tmo,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       restart,
  output logic [7:0] cnt_q,
  output logic       expire,
  output logic       rst_pulse
);
  localparam int PW = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(SEC_PER_MIN - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [7:0]    cnt_d;
  logic          unit_tick;

  assign unit_tick = sec_tick && (!unit_min || (pre_q == PRE_LAST));

  always_comb begin
    cnt_d  = cnt_q;
    pre_d  = pre_q;
    expire = 1'b0;
    if (load) begin
      cnt_d = load_val;
      pre_d = '0;
    end else if (restart) begin
      cnt_d = tmo;
      pre_d = '0;
    end else if (en && sec_tick) begin
      if (unit_min) pre_d = (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
      if (unit_tick) begin
        if (cnt_q <= 8'd1) begin
          cnt_d  = '0;
          expire = 1'b1;
        end else begin
          cnt_d = cnt_q - 8'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      pre_q     <= '0;
      rst_pulse <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      pre_q     <= pre_d;
      rst_pulse <= expire;
    end
  end
endmodule

// File: rtl/kl_wdog_ctrl.sv
module kl_wdog_ctrl #(
  parameter int SEC_PER_MIN = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_port,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       sec_tick,
  input  logic       kbd_irq,
  input  logic       mouse_irq,
  output logic       wdt_rst
);
  logic [1:0] rst_sync;
  logic       rst_s_n;
  logic       cfg_open, close_evt;
  logic [7:0] cur_idx, wd_page, wd_cnt, wd_tmo;
  logic       wd_en, wd_unit, kb_en, ms_en, tmo_wr, expire, restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  assign restart = wd_en && ((kb_en && kbd_irq) || (ms_en && mouse_irq));

  kl_key_fsm u_key (
    .clk(clk), .rst_n(rst_s_n),
    .idx_wr(host_wr && !host_port), .wdata(host_wdata),
    .cfg_open(cfg_open), .close_evt(close_evt), .idx_q(cur_idx)
  );

  kl_wd_regs u_regs (
    .clk(clk), .rst_n(rst_s_n),
    .cfg_open(cfg_open), .close_evt(close_evt),
    .dat_wr(host_wr && host_port), .idx(cur_idx), .wdata(host_wdata),
    .expire(expire), .cnt(wd_cnt),
    .en_o(wd_en), .unit_min_o(wd_unit), .tmo_o(wd_tmo),
    .kb_en_o(kb_en), .ms_en_o(ms_en), .tmo_wr_o(tmo_wr),
    .page_o(wd_page), .rdata(host_rdata)
  );

  kl_wd_timer #(.SEC_PER_MIN(SEC_PER_MIN)) u_tmr (
    .clk(clk), .rst_n(rst_s_n),
    .sec_tick(sec_tick), .en(wd_en), .unit_min(wd_unit), .tmo(wd_tmo),
    .load(tmo_wr), .load_val(host_wdata), .restart(restart),
    .cnt_q(wd_cnt), .expire(expire), .rst_pulse(wdt_rst)
  );
endmodule

// File: rtl/kl_wdog_chk.sv
module kl_wdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       host_port,
  input logic [7:0] host_wdata,
  input logic [7:0] host_rdata,
  input logic       wdt_rst,
  input logic       cfg_open,
  input logic       wd_en,
  input logic [7:0] wd_page,
  input logic [7:0] wd_cnt
);
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  p_pulse_cnt_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> (wd_cnt == 8'd0));

  p_pulse_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> $past(wd_en));

  p_closed_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |-> (host_rdata == 8'h00));

  p_close_clears_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_port && host_wdata == 8'hAA && cfg_open)
      |=> (!cfg_open && wd_page == 8'h00));

  p_idle_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_en && !(host_wr && host_port)) |=> $stable(wd_cnt));
endmodule

bind kl_wdog_ctrl kl_wdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_port(host_port),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .wdt_rst(wdt_rst),
  .cfg_open(cfg_open), .wd_en(wd_en), .wd_page(wd_page), .wd_cnt(wd_cnt)
);

// File: tb/kl_wdog_ctrl_tb.sv
`timescale 1ns/1ps
module kl_wdog_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_wr, host_port, sec_tick, kbd_irq, mouse_irq;
  logic [7:0] host_wdata, host_rdata;
  logic       wdt_rst;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int p0;
  bit done = 0;
  logic       rd_req = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  kl_wdog_ctrl #(.SEC_PER_MIN(60)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_port(host_port),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .sec_tick(sec_tick),
    .kbd_irq(kbd_irq), .mouse_irq(mouse_irq), .wdt_rst(wdt_rst)
  );

  always @(negedge clk) if (wdt_rst === 1'b1) pulses++;

  always @(negedge clk) begin
    if (rd_req) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (host_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata actual %02h expected %02h", t, host_rdata, e);
      end
    end
  end

  task automatic chk(input int act, input int exp, input string t);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic wr(input logic p, input logic [7:0] v);
    host_wr = 1'b1; host_port = p; host_wdata = v;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] e, input string t);
    host_port = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_req = 1'b1;
    @(posedge clk); #1;
    rd_req = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      sec_tick = 1'b1;
      @(posedge clk); #1;
      sec_tick = 1'b0;
    end
  endtask

  task automatic pulse_irq(input bit mouse);
    if (mouse) mouse_irq = 1'b1; else kbd_irq = 1'b1;
    @(posedge clk); #1;
    mouse_irq = 1'b0; kbd_irq = 1'b0;
  endtask

  task automatic settle_pulses();
    @(negedge clk); @(posedge clk); #1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_port = 1'b0; host_wdata = '0;
    sec_tick = 1'b0; kbd_irq = 1'b0; mouse_irq = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    rd(8'h00, "R1 closed read");
    @(negedge clk); chk(wdt_rst, 0, "R1 reset output low");
    @(posedge clk); #1;

    // R2 writes while closed are ignored
    wr(0, 8'h30); wr(1, 8'h01); wr(0, 8'hF6); wr(1, 8'h02);
    // R3 broken key sequence
    wr(0, 8'h87); wr(0, 8'h55); wr(0, 8'h87); wr(0, 8'h07); wr(1, 8'h08);
    rd(8'h00, "R3 still closed after broken key");

    wr(0, 8'h87); wr(0, 8'h87);
    wr(0, 8'h07); rd(8'h00, "R3 page write while closed ignored");
    // R4 page gating
    wr(0, 8'h30); rd(8'h00, "R4 unselected page reads zero");
    wr(1, 8'h01);
    wr(0, 8'h07); wr(1, 8'h08); rd(8'h08, "R4 page register readback");
    wr(0, 8'h30); rd(8'h00, "R4 write before page select ignored, R2 closed write ignored");
    wr(0, 8'hF6); rd(8'h00, "R2 closed timeout write ignored");

    // R5 field layout
    wr(0, 8'hF5); wr(1, 8'hFF); rd(8'h08, "R5 unit field mask");
    wr(1, 8'h00); rd(8'h00, "R5 unit clear");
    wr(0, 8'hF7); wr(1, 8'hFF); rd(8'hC0, "R5 restart fields mask");
    wr(1, 8'h00);
    wr(0, 8'h41); wr(1, 8'hFF); rd(8'h00, "R5 unimplemented index");
    wr(0, 8'h30); wr(1, 8'hFE); rd(8'h00, "R5 enable bit0 only");
    wr(1, 8'hFF); rd(8'h01, "R5 enable set"); wr(1, 8'h00);

    // R6 close key
    wr(0, 8'hAA); rd(8'h00, "R6 closed read");
    wr(0, 8'h30); wr(1, 8'h01);
    wr(0, 8'h87); wr(0, 8'h87);
    wr(0, 8'h07); rd(8'h00, "R6 page cleared on close");
    wr(1, 8'h08);
    wr(0, 8'h30); rd(8'h00, "R6 write after close ignored");

    // R7 countdown in seconds
    wr(0, 8'hF6); wr(1, 8'h03);
    tick(2); rd(8'h03, "R7 disabled holds count");
    wr(0, 8'h30); wr(1, 8'h01); wr(0, 8'hF6);
    tick(1); rd(8'h02, "R7 first decrement");
    tick(1); rd(8'h01, "R7 second decrement");
    p0 = pulses;
    tick(1);
    @(negedge clk); chk(wdt_rst, 1, "R8 reset pulse after expiring tick");
    @(negedge clk); chk(wdt_rst, 0, "R8 reset pulse one cycle wide");
    @(posedge clk); #1;
    chk(pulses - p0, 1, "R8 single pulse");
    rd(8'h00, "R8 count at zero");
    wr(0, 8'h30); rd(8'h00, "R8 enable cleared");

    // R9 keepalive
    wr(1, 8'h01); wr(0, 8'hF6); wr(1, 8'h02);
    tick(1); rd(8'h01, "R9 count from written value");
    wr(1, 8'h03); rd(8'h03, "R9 keepalive reload");
    tick(1); rd(8'h02, "R9 counting after keepalive");

    // R10 restart sources
    wr(0, 8'hF7); wr(1, 8'h00); pulse_irq(0);
    wr(0, 8'hF6); rd(8'h02, "R10 keyboard ignored when bit clear");
    wr(0, 8'hF7); wr(1, 8'h40); pulse_irq(0);
    wr(0, 8'hF6); rd(8'h03, "R10 keyboard reloads");
    tick(1); pulse_irq(1); rd(8'h02, "R10 mouse ignored when bit clear");
    wr(0, 8'hF7); wr(1, 8'h80); pulse_irq(1);
    wr(0, 8'hF6); rd(8'h03, "R10 mouse reloads");

    // R12 same-cycle contention
    p0 = pulses;
    tick(2); rd(8'h01, "R12 count at one");
    sec_tick = 1'b1; mouse_irq = 1'b1;
    @(posedge clk); #1;
    sec_tick = 1'b0; mouse_irq = 1'b0;
    rd(8'h03, "R12 restart beats expiry");
    tick(2);
    sec_tick = 1'b1;
    wr(1, 8'h05);
    sec_tick = 1'b0;
    rd(8'h05, "R12 write beats expiry");
    wr(0, 8'h30); rd(8'h01, "R12 enable kept");
    settle_pulses();
    chk(pulses - p0, 0, "R12 no reset pulse");

    // R11 minutes mode
    wr(0, 8'hF5); wr(1, 8'h08);
    wr(0, 8'hF6); wr(1, 8'h01);
    p0 = pulses;
    tick(59); rd(8'h01, "R11 no decrement before a full minute");
    settle_pulses();
    chk(pulses - p0, 0, "R11 no pulse before a full minute");
    tick(1); settle_pulses();
    chk(pulses - p0, 1, "R11 expiry after one minute");
    rd(8'h00, "R11 count zero");

    wr(0, 8'hAA);
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule